// File: doc/BRIEF.md
# Serial Clock Synthesizer Programming Sequencer

This block loads one control word into one register of an external programmable clock synthesizer over a two-wire programming link made of a clock line and a data line. The host presents a 3-bit register address and a 21-bit control word and pulses a start request. The block then drives a five-pulse unlock preamble and a start pattern. It follows with 24 encoded bits, data first and then address, and finishes with a stop pattern. When the transfer is over it raises a one-cycle done pulse.

Each bit is not sent as a plain level. It is sent as a fixed sequence of clock/data phases, and the sequence for a one differs from the sequence for a zero. Every phase is held for `PHASE_CYC` system clocks so that the target's setup and hold times are met. Each half of an unlock or start pulse counts as one phase. The host packs the word with these fields:
- bits 20:17: VCO range index
- bits 16:10: P minus 3
- bits 9:7: output divider select
- bits 6:0: Q minus 2

The block moves the word as opaque bits.

Top module: `clkprog_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `prog_clk`, `prog_dat`, `busy` and `done` are all 0.
- R2: The transfer opens with the unlock preamble. It is the phase (clk,dat)=(0,1) followed by five pulses of (1,1),(0,1), which is 11 phases in all.
- R3: The start pattern follows the preamble as the phases (0,0),(1,0),(0,0),(1,0).
- R4: A zero bit is sent as the five phases (1,0),(1,1),(0,1),(0,0),(1,0).
- R5: A one bit is sent as the four phases (1,0),(0,0),(0,1),(1,1).
- R6: The 24 encoded bits are `word[0]` through `word[20]`, then `addr[0]` through `addr[2]`, in that order.
- R7: The stop pattern is the phases (1,1),(0,1),(1,1),(1,0), and it ends the transfer.
- R8: Every phase holds its line values for exactly `PHASE_CYC` clocks. A transfer therefore lasts (115 + number of zero bits) × `PHASE_CYC` clocks.
- R9: `busy` rises in the cycle after an accepted request and stays high through the last stop phase. `done` is high for exactly one cycle, which is the first cycle with `busy` low.
- R10: A start request made while `busy` is high is ignored. The waveform and the length of the running transfer are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled only while idle |
| reg_addr | input | 3 | Target register address |
| ctrl_word | input | 21 | Control word to load |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at end of transfer |
| prog_clk | output | 1 | Programming clock line |
| prog_dat | output | 1 | Programming data line |

## Verification
A corrupted phase index or segment shows up at once on the two lines. The wrong pattern appears within one phase time, or a phase is dropped or repeated. A slip in the bit shift register or the bits-left counter shows up later, as a wrong bit value in a later bit slot. It also changes the transfer length by some multiple of `PHASE_CYC`, so the position of `done` moves. A timer fault stretches or shortens every phase, and the first phase boundary exposes it.

// File: rtl/clkprog_pkg.sv
package clkprog_pkg;

    localparam int DEF_WORD_W    = 21;
    localparam int DEF_ADDR_W    = 3;
    localparam int UNLOCK_PULSES = 5;
    localparam int IDX_W         = 4;
    localparam int UNLOCK_LAST   = 2 * UNLOCK_PULSES;

    typedef enum logic [2:0] {
        SEG_IDLE,
        SEG_UNLOCK,
        SEG_START,
        SEG_BIT,
        SEG_STOP
    } seg_e;

    typedef struct packed {
        logic clk;
        logic dat;
    } line_t;

    // Line levels for a given phase of a given segment.
    function automatic line_t phase_line(seg_e seg, logic [IDX_W-1:0] idx, logic bitval);
        line_t l;
        l = '{clk: 1'b0, dat: 1'b0};
        case (seg)
            SEG_UNLOCK: begin
                l.dat = 1'b1;
                l.clk = (idx != '0) && idx[0];
            end
            SEG_START: begin
                l.dat = 1'b0;
                l.clk = idx[0];
            end
            SEG_BIT: begin
                if (bitval) begin
                    case (idx)
                        4'd0:    l = '{clk: 1'b1, dat: 1'b0};
                        4'd1:    l = '{clk: 1'b0, dat: 1'b0};
                        4'd2:    l = '{clk: 1'b0, dat: 1'b1};
                        default: l = '{clk: 1'b1, dat: 1'b1};
                    endcase
                end else begin
                    case (idx)
                        4'd0:    l = '{clk: 1'b1, dat: 1'b0};
                        4'd1:    l = '{clk: 1'b1, dat: 1'b1};
                        4'd2:    l = '{clk: 1'b0, dat: 1'b1};
                        4'd3:    l = '{clk: 1'b0, dat: 1'b0};
                        default: l = '{clk: 1'b1, dat: 1'b0};
                    endcase
                end
            end
            SEG_STOP: begin
                case (idx)
                    4'd0:    l = '{clk: 1'b1, dat: 1'b1};
                    4'd1:    l = '{clk: 1'b0, dat: 1'b1};
                    4'd2:    l = '{clk: 1'b1, dat: 1'b1};
                    default: l = '{clk: 1'b1, dat: 1'b0};
                endcase
            end
            default: l = '{clk: 1'b0, dat: 1'b0};
        endcase
        return l;
    endfunction

    // True on the final phase of a segment.
    function automatic logic phase_last(seg_e seg, logic [IDX_W-1:0] idx, logic bitval);
        case (seg)
            SEG_UNLOCK: return idx == IDX_W'(UNLOCK_LAST);
            SEG_START:  return idx == IDX_W'(3);
            SEG_BIT:    return idx == (bitval ? IDX_W'(3) : IDX_W'(4));
            SEG_STOP:   return idx == IDX_W'(3);
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/clkprog_timer.sv
module clkprog_timer #(
    parameter int PHASE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic active,
    output logic tick
);
    localparam int CNT_W = (PHASE_CYC < 2) ? 1 : $clog2(PHASE_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = active && (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (active) begin
            cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
        end
    end

    // R8: the phase counter never exceeds the hold count
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_LAST);

endmodule

// File: rtl/clkprog_shifter.sv
module clkprog_shifter #(
    parameter int WORD_W = 21,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic [WORD_W-1:0] word,
    input  logic [ADDR_W-1:0] addr,
    output logic              cur_bit,
    output logic              last_bit
);
    localparam int FRAME_W = WORD_W + ADDR_W;
    localparam int LEFT_W  = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sr;
    logic [LEFT_W-1:0]  left;

    assign cur_bit  = sr[0];
    assign last_bit = (left == LEFT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            left <= '0;
        end else if (load) begin
            sr   <= {addr, word};
            left <= LEFT_W'(FRAME_W);
        end else if (advance && left != '0) begin
            sr   <= {1'b0, sr[FRAME_W-1:1]};
            left <= left - 1'b1;
        end
    end

    // R6: the bits-left count stays within one frame
    a_r6_left_bound: assert property (@(posedge clk) disable iff (rst)
        left <= LEFT_W'(FRAME_W));

    // R6: advancing consumes exactly one bit
    a_r6_one_per_adv: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && left != '0) |=> (left == $past(left) - 1'b1));

endmodule

// File: rtl/clkprog_sequencer.sv
module clkprog_sequencer
    import clkprog_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  logic  tick,
    input  logic  cur_bit,
    input  logic  last_bit,
    output logic  bit_adv,
    output logic  busy,
    output logic  done,
    output line_t line
);
    seg_e             seg;
    logic [IDX_W-1:0] idx;
    logic             last;

    assign last    = phase_last(seg, idx, cur_bit);
    assign line    = phase_line(seg, idx, cur_bit);
    assign busy    = (seg != SEG_IDLE);
    assign bit_adv = tick && last && (seg == SEG_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            seg  <= SEG_IDLE;
            idx  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (seg == SEG_IDLE) begin
                if (accept) begin
                    seg <= SEG_UNLOCK;
                    idx <= '0;
                end
            end else if (tick) begin
                if (!last) begin
                    idx <= idx + 1'b1;
                end else begin
                    idx <= '0;
                    case (seg)
                        SEG_UNLOCK: seg <= SEG_START;
                        SEG_START:  seg <= SEG_BIT;
                        SEG_BIT:    seg <= last_bit ? SEG_STOP : SEG_BIT;
                        default: begin
                            seg  <= SEG_IDLE;
                            done <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    // R8: the lines only move on a phase boundary
    a_r8_hold_phase: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(line));

    // R9: done follows only the final stop phase
    a_r9_done_src: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(seg) == SEG_STOP) && (seg == SEG_IDLE));

endmodule

// File: rtl/clkprog_seq.sv
module clkprog_seq
    import clkprog_pkg::*;
#(
    parameter int PHASE_CYC = 4,
    parameter int WORD_W    = DEF_WORD_W,
    parameter int ADDR_W    = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] ctrl_word,
    output logic              busy,
    output logic              done,
    output logic              prog_clk,
    output logic              prog_dat
);
    logic  accept;
    logic  tick;
    logic  cur_bit;
    logic  last_bit;
    logic  bit_adv;
    line_t line;

    assign accept   = start && !busy;
    assign prog_clk = line.clk;
    assign prog_dat = line.dat;

    clkprog_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .active  (busy),
        .tick    (tick)
    );

    clkprog_shifter #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_shifter (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .advance  (bit_adv),
        .word     (ctrl_word),
        .addr     (reg_addr),
        .cur_bit  (cur_bit),
        .last_bit (last_bit)
    );

    clkprog_sequencer u_seqr (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .tick     (tick),
        .cur_bit  (cur_bit),
        .last_bit (last_bit),
        .bit_adv  (bit_adv),
        .busy     (busy),
        .done     (done),
        .line     (line)
    );

    // R1: idle lines are low
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!prog_clk && !prog_dat));

    // R2: a transfer begins with data high and clock low
    a_r2_first_phase: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!prog_clk && prog_dat));

    // R9: done only in the first cycle after busy falls
    a_r9_done_edge: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    // R10: a request while busy does not disturb the running transfer
    a_r10_ignore: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !tick) |=> busy);

endmodule

// File: tb/clkprog_seq_bench.sv
module clkprog_seq_bench;
    localparam int H      = 3;
    localparam int WW     = 21;
    localparam int AW     = 3;
    localparam int MAXC   = 600;
    localparam int MAXP   = 160;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [WW-1:0] word = '0;
    logic busy, done, pclk, pdat;

    int checks = 0;
    int errs   = 0;

    logic rc [MAXC];
    logic rd [MAXC];
    int   rlen;
    logic ec [MAXP];
    logic ed [MAXP];
    int   et [MAXP];
    int   np;

    always #2 clk = ~clk;

    clkprog_seq #(.PHASE_CYC(H)) u_clkprog_seq (
        .clk(clk), .rst(rst), .start(start), .reg_addr(addr), .ctrl_word(word),
        .busy(busy), .done(done), .prog_clk(pclk), .prog_dat(pdat)
    );

    task automatic check(input string req, input bit ok, input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic addp(input logic c, input logic d, input int tag);
        ec[np] = c; ed[np] = d; et[np] = tag; np++;
    endtask

    // tags: 2 unlock, 3 start, 4 zero bit, 5 one bit, 7 stop
    task automatic build(input logic [WW-1:0] w, input logic [AW-1:0] a);
        logic [WW+AW-1:0] fr;
        np = 0;
        fr = {a, w};
        addp(0, 1, 2);                                  // R2
        for (int k = 0; k < 5; k++) begin addp(1, 1, 2); addp(0, 1, 2); end
        addp(0, 0, 3); addp(1, 0, 3); addp(0, 0, 3); addp(1, 0, 3); // R3
        for (int b = 0; b < WW + AW; b++) begin        // R6 order
            if (fr[b]) begin                            // R5
                addp(1, 0, 5); addp(0, 0, 5); addp(0, 1, 5); addp(1, 1, 5);
            end else begin                              // R4
                addp(1, 0, 4); addp(1, 1, 4); addp(0, 1, 4); addp(0, 0, 4); addp(1, 0, 4);
            end
        end
        addp(1, 1, 7); addp(0, 1, 7); addp(1, 1, 7); addp(1, 0, 7); // R7
    endtask

    task automatic run_frame(input logic [WW-1:0] w, input logic [AW-1:0] a,
                             input int poke_at, input string ordtag);
        int bad [8];
        int first_act, first_exp, zeros;
        for (int t = 0; t < 8; t++) bad[t] = 0;
        build(w, a);
        @(negedge clk);
        word = w; addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 busy rises", busy === 1'b1, int'(busy), 1);
        rlen = 0;
        while (busy === 1'b1 && rlen < MAXC) begin
            rc[rlen] = pclk; rd[rlen] = pdat; rlen++;
            if (rlen == poke_at) begin
                word = ~w; addr = ~a; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check("R9 done pulse", done === 1'b1, int'(done), 1);
        check("R1 idle lines", pclk === 1'b0 && pdat === 1'b0, {pclk, pdat}, 0);
        zeros = 0;
        for (int b = 0; b < WW + AW; b++) if (!({a, w} >> b & 1)) zeros++;
        check(poke_at > 0 ? "R10 length" : "R8 length", rlen == (115 + zeros) * H, rlen, (115 + zeros) * H);
        first_act = 0; first_exp = 0;
        for (int c = 0; c < rlen && c < np * H; c++) begin
            int p;
            p = c / H;
            if (rc[c] !== ec[p] || rd[c] !== ed[p]) begin
                if (bad[et[p]] == 0 && bad[0] == 0) begin
                    first_act = {rc[c], rd[c]}; first_exp = {ec[p], ed[p]};
                end
                bad[et[p]]++; bad[0]++;
            end
        end
        check("R2 unlock", bad[2] == 0, first_act, first_exp);
        check("R3 start pattern", bad[3] == 0, first_act, first_exp);
        check("R4 zero bit", bad[4] == 0, first_act, first_exp);
        check("R5 one bit", bad[5] == 0, first_act, first_exp);
        check("R7 stop", bad[7] == 0, first_act, first_exp);
        check(ordtag, bad[0] == 0, first_act, first_exp);
        @(negedge clk);
        check("R9 done single", done === 1'b0, int'(done), 0);
        check("R1 idle", busy === 1'b0, int'(busy), 0);
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", busy === 0 && done === 0 && pclk === 0 && pdat === 0,
              {busy, done, pclk, pdat}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 after reset", busy === 0 && done === 0 && pclk === 0 && pdat === 0,
              {busy, done, pclk, pdat}, 0);
        // near-exhaustive sweep over addresses with several word patterns
        for (int a = 0; a < 8; a++) begin
            run_frame(21'h000000, AW'(a), 0, "R6 order");
            run_frame(21'h1FFFFF, AW'(a), 0, "R6 order");
            run_frame(21'h155555, AW'(a), 0, "R6 order");
            run_frame(21'h0AAAAA, AW'(a), 0, "R6 order");
            run_frame(WW'((a * 32'h2F1B3 + 32'h5A8BC) & 32'h1FFFFF), AW'(a), 0, "R6 order");
        end
        // single-bit walk exposes any reordering (R6)
        for (int k = 0; k < WW; k++) run_frame(WW'(1) << k, 3'd0, 0, "R6 walk word");
        for (int j = 0; j < AW; j++) run_frame('0, AW'(1) << j, 0, "R6 walk addr");
        // request while busy is ignored (R10)
        run_frame(21'h0960AC, 3'd2, 40, "R10 waveform");
        run_frame(21'h0D44A3, 3'd3, 200, "R10 waveform");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule